// File: doc/BRIEF.md
# Synchronization Correlation Peak Detector

This block sits behind three matched filters that each correlate the received baseband stream against one candidate synchronization sequence. Each filter delivers a squared-magnitude correlation value per received sample, and the block also receives the power of the same sample. Every stream advances only on cycles where `in_valid` is high, so a sample rate far below the clock rate costs nothing extra.

An adaptive threshold is formed from the mean received power over the most recent 128 samples, scaled up by a power-of-two factor. When any of the three correlation values rises strictly above that threshold, the block opens a ten-sample search window that begins at the crossing sample. Within the window it tracks the largest correlation value seen on any stream. When the window closes it publishes the peak value, the index of the stream that produced it and the sample number at which it occurred, and it raises a single-cycle strobe. It then re-arms at once, so the next occurrence of the sequence within a radio frame is caught.

Top module: `sync_peak_detector`

## Requirements
- R1: While `rst_n` is low, and after it is released, `det_strobe` is 0 and `peak_pwr`, `peak_seq` and `peak_time` are 0. A reset asserted in the middle of a search discards that search, and no strobe follows from it.
- R2: The threshold applied to a sample is the mean of `pwr_in` over the 128 valid samples that precede it (the integer part of their sum divided by 128), shifted left by `THR_SHIFT` (default 2). Before 128 samples have been seen, the missing samples count as 0. The power of the sample under test does not count toward its own threshold.
- R3: A search starts only when at least one correlation value is strictly greater than the threshold. A value equal to the threshold starts nothing.
- R4: A search covers the crossing sample and the next 9 valid samples. `det_strobe` goes high for exactly one clock cycle, on the cycle after the clock edge that takes the tenth sample.
- R5: `peak_pwr` reports the largest correlation value seen on any of the three streams over the whole window.
- R6: `peak_seq` encodes the winning stream as 0 for `corr_a`, 1 for `corr_b` and 2 for `corr_c`. When values are equal, the earlier sample wins first, and then the lower stream index wins.
- R7: `peak_time` is the zero-based count of valid samples since reset, taken at the winning sample, modulo 2^`TW`.
- R8: Crossings that occur during a search do not restart the search. The first valid sample after the tenth sample of a window can start a new search.
- R9: Cycles with `in_valid` low are ignored. The peak outputs change only together with `det_strobe` and hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Marks a cycle that carries a new received sample |
| corr_a | input | CW (24) | Squared correlation magnitude for sequence 0 |
| corr_b | input | CW (24) | Squared correlation magnitude for sequence 1 |
| corr_c | input | CW (24) | Squared correlation magnitude for sequence 2 |
| pwr_in | input | PW (16) | Power of the received sample |
| det_strobe | output | 1 | One-cycle pulse when a search window closes |
| peak_pwr | output | CW (24) | Largest correlation value in the last window |
| peak_seq | output | 2 | Index of the stream that gave the peak |
| peak_time | output | TW (16) | Sample count at the winning sample |

## Verification
The correlation patterns are chosen so that each one separates a correct detector from a plausible wrong one. One stream sits exactly at the threshold and then one count above it, which tells a strict comparison from a non-strict one. A later, larger peak on another stream tells a full-window search from stopping at the first crossing. Equal values at later samples and on other streams tell the correct tie order from its reverse, and a crossing right after a window closes tells immediate re-arming from a dead period. A long change in power level, followed by a crossing sample that carries a very large power, shows that the threshold tracks the moving mean and leaves out the sample under test. An invalid cycle that carries huge values checks that qualified samples alone are counted.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int NSEQ = 3;
  localparam int SEQ_W = 2;
endpackage

// File: rtl/spd_sample_counter.sv
module spd_sample_counter #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic [TW-1:0] count
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (in_valid) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/spd_power_avg.sv
module spd_power_avg #(
  parameter int PW        = 16,
  parameter int AVG_LOG2  = 7,
  parameter int THR_SHIFT = 2,
  parameter int CW        = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [PW-1:0] pwr_in,
  output logic [CW-1:0] thresh
);
  localparam int DEPTH = 1 << AVG_LOG2;
  localparam int SW    = PW + AVG_LOG2;

  logic [PW-1:0]       hist [DEPTH];
  logic [AVG_LOG2-1:0] wr_q, wr_d;
  logic [SW-1:0]       sum_q, sum_d;
  logic [PW-1:0]       mean;

  // running sum: add newest sample, drop the one it overwrites
  always_comb begin
    wr_d  = wr_q;
    sum_d = sum_q;
    if (in_valid) begin
      wr_d  = wr_q + 1'b1;
      sum_d = sum_q + SW'(pwr_in) - SW'(hist[wr_q]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      sum_q <= '0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else begin
      wr_q  <= wr_d;
      sum_q <= sum_d;
      if (in_valid) hist[wr_q] <= pwr_in;
    end
  end

  assign mean   = sum_q[SW-1:AVG_LOG2];
  assign thresh = CW'(mean) << THR_SHIFT;
endmodule

// File: rtl/spd_max_pick.sv
module spd_max_pick #(
  parameter int N  = 3,
  parameter int CW = 24,
  parameter int IW = 2
) (
  input  logic [N-1:0][CW-1:0] vals,
  output logic [CW-1:0]        max_val,
  output logic [IW-1:0]        max_idx
);
  // strict compare keeps the lower index on equal values
  always_comb begin
    max_val = vals[0];
    max_idx = '0;
    for (int i = 1; i < N; i++) begin
      if (vals[i] > max_val) begin
        max_val = vals[i];
        max_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/spd_peak_search.sv
module spd_peak_search
  import spd_pkg::*;
#(
  parameter int CW      = 24,
  parameter int TW      = 16,
  parameter int WIN_LEN = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [NSEQ-1:0][CW-1:0] corr,
  input  logic [CW-1:0]          thresh,
  input  logic [TW-1:0]          count,
  output logic                   det_strobe,
  output logic [CW-1:0]          peak_pwr,
  output logic [SEQ_W-1:0]       peak_seq,
  output logic [TW-1:0]          peak_time
);
  localparam int LW = $clog2(WIN_LEN + 1);

  logic             srch_q, srch_d;
  logic [LW-1:0]    left_q, left_d;
  logic [CW-1:0]    best_q, best_d;
  logic [SEQ_W-1:0] bidx_q, bidx_d;
  logic [TW-1:0]    btim_q, btim_d;
  logic             stb_d, stb_q;
  logic [CW-1:0]    opwr_q, opwr_d;
  logic [SEQ_W-1:0] oseq_q, oseq_d;
  logic [TW-1:0]    otim_q, otim_d;

  logic [CW-1:0]    cand;
  logic [SEQ_W-1:0] cand_idx;
  logic             start, better, last;

  spd_max_pick #(.N(NSEQ), .CW(CW), .IW(SEQ_W)) u_pick (
    .vals    (corr),
    .max_val (cand),
    .max_idx (cand_idx)
  );

  always_comb begin
    start  = !srch_q && in_valid && (cand > thresh);
    better = srch_q && in_valid && (cand > best_q);
    last   = (start && (WIN_LEN == 1)) ||
             (srch_q && in_valid && (left_q == LW'(1)));

    srch_d = srch_q;
    left_d = left_q;
    best_d = best_q;
    bidx_d = bidx_q;
    btim_d = btim_q;
    if (start || better) begin
      best_d = cand;
      bidx_d = cand_idx;
      btim_d = count;
    end
    if (start) begin
      srch_d = 1'b1;
      left_d = LW'(WIN_LEN - 1);
    end else if (srch_q && in_valid) begin
      left_d = left_q - 1'b1;
    end
    if (last) srch_d = 1'b0;

    stb_d  = last;
    opwr_d = opwr_q;
    oseq_d = oseq_q;
    otim_d = otim_q;
    if (last) begin
      opwr_d = best_d;
      oseq_d = bidx_d;
      otim_d = btim_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srch_q <= 1'b0;
      left_q <= '0;
      best_q <= '0;
      bidx_q <= '0;
      btim_q <= '0;
      stb_q  <= 1'b0;
      opwr_q <= '0;
      oseq_q <= '0;
      otim_q <= '0;
    end else begin
      srch_q <= srch_d;
      left_q <= left_d;
      best_q <= best_d;
      bidx_q <= bidx_d;
      btim_q <= btim_d;
      stb_q  <= stb_d;
      opwr_q <= opwr_d;
      oseq_q <= oseq_d;
      otim_q <= otim_d;
    end
  end

  assign det_strobe = stb_q;
  assign peak_pwr   = opwr_q;
  assign peak_seq   = oseq_q;
  assign peak_time  = otim_q;
endmodule

// File: rtl/sync_peak_detector.sv
module sync_peak_detector
  import spd_pkg::*;
#(
  parameter int CW        = 24,
  parameter int PW        = 16,
  parameter int TW        = 16,
  parameter int AVG_LOG2  = 7,
  parameter int THR_SHIFT = 2,
  parameter int WIN_LEN   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] corr_a,
  input  logic [CW-1:0] corr_b,
  input  logic [CW-1:0] corr_c,
  input  logic [PW-1:0] pwr_in,
  output logic          det_strobe,
  output logic [CW-1:0] peak_pwr,
  output logic [1:0]    peak_seq,
  output logic [TW-1:0] peak_time
);
  logic [1:0]            rst_sync;
  logic                  rst_int_n;
  logic [CW-1:0]         thresh;
  logic [TW-1:0]         count;
  logic [NSEQ-1:0][CW-1:0] corr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign corr = {corr_c, corr_b, corr_a};

  spd_sample_counter #(.TW(TW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (in_valid),
    .count    (count)
  );

  spd_power_avg #(.PW(PW), .AVG_LOG2(AVG_LOG2), .THR_SHIFT(THR_SHIFT), .CW(CW)) u_avg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (in_valid),
    .pwr_in   (pwr_in),
    .thresh   (thresh)
  );

  spd_peak_search #(.CW(CW), .TW(TW), .WIN_LEN(WIN_LEN)) u_search (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_valid   (in_valid),
    .corr       (corr),
    .thresh     (thresh),
    .count      (count),
    .det_strobe (det_strobe),
    .peak_pwr   (peak_pwr),
    .peak_seq   (peak_seq),
    .peak_time  (peak_time)
  );
endmodule

// File: rtl/sync_peak_detector_chk.sv
module sync_peak_detector_chk #(
  parameter int CW = 24,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          det_strobe,
  input logic [CW-1:0] peak_pwr,
  input logic [1:0]    peak_seq,
  input logic [TW-1:0] peak_time
);
  // R4: strobe lasts a single cycle
  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    det_strobe |=> !det_strobe);

  // R9: strobe only follows a clock edge that took a valid sample
  p_strobe_after_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    det_strobe |-> $past(in_valid));

  // R9: peak outputs move only together with the strobe
  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({peak_pwr, peak_seq, peak_time}) |-> det_strobe);

  // R6: stream index is 0, 1 or 2
  p_seq_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    peak_seq != 2'd3);

  // R3: a reported peak lies strictly above a non-negative threshold
  p_nonzero_peak_r3: assert property (@(posedge clk) disable iff (!rst_n)
    det_strobe |-> (peak_pwr != '0));
endmodule

bind sync_peak_detector sync_peak_detector_chk #(.CW(CW), .TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .det_strobe (det_strobe),
  .peak_pwr   (peak_pwr),
  .peak_seq   (peak_seq),
  .peak_time  (peak_time)
);

// File: tb/sync_peak_detector_tb_top.sv
`timescale 1ns/1ps
module sync_peak_detector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] corr_a, corr_b, corr_c;
  logic [15:0] pwr_in;
  logic        det_strobe;
  logic [23:0] peak_pwr;
  logic [1:0]  peak_seq;
  logic [15:0] peak_time;

  int total = 0;
  int bad   = 0;
  int nsamp = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  sync_peak_detector dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .corr_a(corr_a), .corr_b(corr_b), .corr_c(corr_c), .pwr_in(pwr_in),
    .det_strobe(det_strobe), .peak_pwr(peak_pwr),
    .peak_seq(peak_seq), .peak_time(peak_time)
  );

  typedef struct packed {
    logic        v;
    logic [23:0] a;
    logic [23:0] b;
    logic [23:0] c;
    logic        stb;
    logic [23:0] pp;
    logic [1:0]  ps;
    logic [15:0] pt;
  } vec_t;

  // threshold during the table is 16 << 2 = 64; sample index of row 0 is 128
  localparam vec_t TBL [23] = '{
    '{1'b1, 24'd64,  24'd0,   24'd0,   1'b0, 24'd0,   2'd0, 16'd0},   // R3 equal: no start
    '{1'b1, 24'd65,  24'd10,  24'd3,   1'b0, 24'd0,   2'd0, 16'd0},   // crossing idx 129
    '{1'b1, 24'd5,   24'd5,   24'd5,   1'b0, 24'd0,   2'd0, 16'd0},
    '{1'b1, 24'd0,   24'd0,   24'd0,   1'b0, 24'd0,   2'd0, 16'd0},
    '{1'b1, 24'd0,   24'd0,   24'd200, 1'b0, 24'd0,   2'd0, 16'd0},   // R5 later larger peak
    '{1'b0, 24'd250, 24'd250, 24'd250, 1'b0, 24'd0,   2'd0, 16'd0},   // R9 invalid cycle
    '{1'b1, 24'd200, 24'd200, 24'd0,   1'b0, 24'd0,   2'd0, 16'd0},   // R6 later tie loses
    '{1'b1, 24'd1,   24'd1,   24'd1,   1'b0, 24'd0,   2'd0, 16'd0},
    '{1'b1, 24'd1,   24'd1,   24'd1,   1'b0, 24'd0,   2'd0, 16'd0},
    '{1'b1, 24'd1,   24'd1,   24'd1,   1'b0, 24'd0,   2'd0, 16'd0},
    '{1'b1, 24'd1,   24'd1,   24'd1,   1'b0, 24'd0,   2'd0, 16'd0},
    '{1'b1, 24'd0,   24'd150, 24'd0,   1'b1, 24'd200, 2'd2, 16'd132}, // tenth sample
    '{1'b1, 24'd70,  24'd70,  24'd0,   1'b0, 24'd200, 2'd2, 16'd132}, // R8 re-arm, R6 lower idx
    '{1'b1, 24'd0,   24'd0,   24'd70,  1'b0, 24'd200, 2'd2, 16'd132},
    '{1'b1, 24'd0,   24'd0,   24'd0,   1'b0, 24'd200, 2'd2, 16'd132},
    '{1'b1, 24'd0,   24'd0,   24'd0,   1'b0, 24'd200, 2'd2, 16'd132},
    '{1'b1, 24'd0,   24'd90,  24'd90,  1'b0, 24'd200, 2'd2, 16'd132},
    '{1'b1, 24'd0,   24'd0,   24'd0,   1'b0, 24'd200, 2'd2, 16'd132},
    '{1'b1, 24'd0,   24'd0,   24'd0,   1'b0, 24'd200, 2'd2, 16'd132},
    '{1'b1, 24'd0,   24'd0,   24'd0,   1'b0, 24'd200, 2'd2, 16'd132},
    '{1'b1, 24'd0,   24'd0,   24'd0,   1'b0, 24'd200, 2'd2, 16'd132},
    '{1'b1, 24'd0,   24'd0,   24'd0,   1'b1, 24'd90,  2'd1, 16'd143},
    '{1'b1, 24'd0,   24'd0,   24'd0,   1'b0, 24'd90,  2'd1, 16'd143}  // R9 hold
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input bit v, input int a, input int b, input int c, input int p);
    in_valid = v;
    corr_a = 24'(a); corr_b = 24'(b); corr_c = 24'(c);
    pwr_in = 16'(p);
    @(posedge clk);
    if (v) nsamp++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    corr_a = '0; corr_b = '0; corr_c = '0; pwr_in = '0;
    #1;
    check("R1", "strobe in reset", int'(det_strobe), 0);
    check("R1", "peak_pwr in reset", int'(peak_pwr), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    nsamp = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t_win;
    bit seen;
    @(negedge clk);
    do_reset();
    check("R1", "strobe after release", int'(det_strobe), 0);
    check("R1", "peak_seq after release", int'(peak_seq), 0);
    check("R1", "peak_time after release", int'(peak_time), 0);

    // R2 warm-up: 128 samples of power 16 give threshold 64
    seen = 0;
    for (int i = 0; i < 128; i++) begin
      step(1'b1, 0, 0, 0, 16);
      if (det_strobe) seen = 1;
    end
    check("R3", "no strobe with zero correlation", int'(seen), 0);

    // table walk
    for (int r = 0; r < 23; r++) begin
      step(TBL[r].v, int'(TBL[r].a), int'(TBL[r].b), int'(TBL[r].c), 16);
      check("R4", $sformatf("strobe row %0d", r), int'(det_strobe), int'(TBL[r].stb));
      check("R5", $sformatf("peak_pwr row %0d", r), int'(peak_pwr), int'(TBL[r].pp));
      check("R6", $sformatf("peak_seq row %0d", r), int'(peak_seq), int'(TBL[r].ps));
      check("R7", $sformatf("peak_time row %0d", r), int'(peak_time), int'(TBL[r].pt));
    end

    // R2: raise power to 32 for 128 samples, threshold becomes 128
    for (int i = 0; i < 128; i++) step(1'b1, 0, 0, 0, 32);
    // R3: value equal to threshold must not start a search
    step(1'b1, 128, 0, 0, 32);
    seen = 0;
    for (int i = 0; i < 11; i++) begin
      step(1'b1, 0, 0, 0, 32);
      if (det_strobe) seen = 1;
    end
    check("R3", "equal value starts nothing", int'(seen), 0);
    // R2: crossing sample carries huge power that must not raise its own threshold
    t_win = nsamp;
    step(1'b1, 0, 129, 0, 65535);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 0, 0, 0, 32);
      if (det_strobe) seen = 1;
    end
    check("R4", "no early strobe", int'(seen), 0);
    step(1'b1, 0, 0, 0, 32);
    check("R2", "strobe with adapted threshold", int'(det_strobe), 1);
    check("R5", "peak_pwr adapted", int'(peak_pwr), 129);
    check("R6", "peak_seq stream b", int'(peak_seq), 1);
    check("R7", "peak_time adapted", int'(peak_time), t_win);

    // R7: after reset, threshold 0 and first sample index 0
    do_reset();
    step(1'b1, 5, 0, 0, 0);
    for (int i = 0; i < 9; i++) step(1'b1, 0, 0, 0, 0);
    check("R4", "strobe after reset window", int'(det_strobe), 1);
    check("R5", "peak_pwr first window", int'(peak_pwr), 5);
    check("R7", "peak_time zero", int'(peak_time), 0);

    // R1: reset in the middle of a search discards it
    step(1'b1, 0, 0, 7, 0);
    for (int i = 0; i < 3; i++) step(1'b1, 0, 0, 0, 0);
    do_reset();
    check("R1", "peak_pwr cleared", int'(peak_pwr), 0);
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 0, 0, 0, 0);
      if (det_strobe) seen = 1;
    end
    check("R1", "no strobe from discarded search", int'(seen), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule